// File: doc/BRIEF.md
# Interleaved Banked Dual-Read Memory

A scratchpad memory made of eight banks, each one halfword (16 bits) wide, with consecutive halfwords of the byte address space placed in consecutive banks. The placement wraps back to the first bank after the eighth. Every aligned 32-bit word therefore spans two neighbouring banks. Two 32-bit read ports and one 32-bit write port are offered. The read ports use a valid/ready handshake, and the write port is fire-and-forget.

Two reads that arrive in the same cycle are served together unless their bank numbers are equal modulo 4. Aligned operands whose byte addresses differ by 4 modulo 8 therefore never clash. On a clash, port 0 is served first. Port 1 sees ready low for that cycle and is served on the following cycle, when it holds priority. The arbiter has two named states. S_FREE is the idle and default state, and it moves to S_HOLD on a clash between two aligned, valid reads. S_HOLD gives port 1 the banks and always returns to S_FREE after one cycle. Read data is registered. Writes are never stalled, and a read of a word that is written in the same cycle returns the old contents. A request that is not 4-byte aligned is accepted, dropped, and flagged. The per-bank depth is a parameter, so the full-size configuration is 3072 rows per bank.

Top module: `banked_dual_read_mem`

## Requirements
- R1: After reset, both read-ready outputs are high, and both read-valid outputs and the error flag are low.
- R2: A word written at an aligned byte address is returned unchanged by a later read of that address on either port. The lower halfword comes from the lower address.
- R3: Two valid, aligned reads whose address bit 2 differs (bank numbers not equal modulo 4) are both accepted in the same cycle, with both ready outputs high.
- R4: Two valid, aligned reads whose address bit 2 is equal (bank numbers equal modulo 4) form a clash. In S_FREE, port 0 is accepted and port 1 ready is low for that cycle. The arbiter then enters S_HOLD.
- R5: In S_HOLD, port 1 ready is high. Port 0 ready is low only if the port 0 request clashes with the port 1 request. The arbiter returns to S_FREE on the next cycle.
- R6: A read's valid output and data appear on the clock edge that accepts the request, so they are seen one cycle after the request is presented. They last exactly one cycle for each accepted read.
- R7: A read and a write to the same word in the same cycle return the data held before the write. The new data is returned by later reads.
- R8: A request whose address bits [1:0] are not zero is accepted, produces no read data and no memory change, and raises the error flag for one cycle after the accepting edge.
- R9: A write is taken in every cycle in which it is valid and aligned, whatever the read ports are doing, including during a clash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_valid | input | 1 | Port 0 read request |
| rd0_addr | input | AW | Port 0 byte address |
| rd0_ready | output | 1 | Port 0 request accepted this cycle |
| rd0_rvalid | output | 1 | Port 0 read data valid |
| rd0_data | output | 32 | Port 0 read data |
| rd1_valid | input | 1 | Port 1 read request |
| rd1_addr | input | AW | Port 1 byte address |
| rd1_ready | output | 1 | Port 1 request accepted this cycle |
| rd1_rvalid | output | 1 | Port 1 read data valid |
| rd1_data | output | 32 | Port 1 read data |
| wr_valid | input | 1 | Write request |
| wr_addr | input | AW | Write byte address |
| wr_data | input | 32 | Write data |
| err_misalign | output | 1 | Misaligned request dropped last cycle |

## Verification
The ready outputs are combinational and are compared in the same cycle the request is driven. Read data and the error flag are due on the accepting edge, and a stalled port 1 request is due one edge later than its first presentation. The bench drives requests just after a falling edge and samples ready shortly after that. Each accepted read is queued with the cycle number in which its data is due, and a monitor at each falling edge pops the queue and compares both the data and the cycle. This catches early, late, missing and unrequested results, as well as wrong values.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
    localparam int NBANK  = 8;
    localparam int HWIDTH = 16;
    localparam int WWIDTH = 2 * HWIDTH;

    typedef enum logic [0:0] {
        S_FREE = 1'b0,
        S_HOLD = 1'b1
    } arb_state_e;
endpackage

// File: rtl/bdr_bank.sv
module bdr_bank #(
    parameter int ROWS  = 16,
    parameter int ROW_W = $clog2(ROWS),
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             we,
    input  logic [ROW_W-1:0] waddr,
    input  logic [DW-1:0]    wdata,
    input  logic             re,
    input  logic [ROW_W-1:0] raddr,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] cells [ROWS];

    // read samples the old contents; write lands at the same edge
    always_ff @(posedge clk) begin
        if (re) rdata <= cells[raddr];
        if (we) cells[waddr] <= wdata;
    end
endmodule

// File: rtl/bdr_arbiter.sv
module bdr_arbiter
    import bdr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd0_valid,
    input  logic rd1_valid,
    input  logic rd0_ok,
    input  logic rd1_ok,
    input  logic same_half,
    output logic rd0_ready,
    output logic rd1_ready
);
    arb_state_e state, state_nxt;
    logic       clash;

    assign clash = rd0_valid && rd1_valid && rd0_ok && rd1_ok && same_half;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_FREE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = S_FREE;
        unique case (state)
            S_FREE:  state_nxt = clash ? S_HOLD : S_FREE;
            S_HOLD:  state_nxt = S_FREE;
            default: state_nxt = S_FREE;
        endcase
    end

    always_comb begin
        rd0_ready = 1'b1;
        rd1_ready = 1'b1;
        unique case (state)
            S_FREE:  rd1_ready = !clash;
            S_HOLD:  rd0_ready = !clash;
            default: ;
        endcase
    end

    // R4: a stalled port 1 is granted on the very next cycle
    a_r4_stall_then_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FREE && rd1_valid && !rd1_ready) |=> (state == S_HOLD && rd1_ready));

    // R5: the hold state lasts one cycle
    a_r5_hold_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD) |=> (state == S_FREE));

    // R5: hold is only ever entered after port 1 was refused
    a_r5_hold_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD) |-> $past(rd1_valid && !rd1_ready));
endmodule

// File: rtl/banked_dual_read_mem.sv
module banked_dual_read_mem
    import bdr_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int AW   = $clog2(ROWS) + 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd0_valid,
    input  logic [AW-1:0] rd0_addr,
    output logic          rd0_ready,
    output logic          rd0_rvalid,
    output logic [31:0]   rd0_data,
    input  logic          rd1_valid,
    input  logic [AW-1:0] rd1_addr,
    output logic          rd1_ready,
    output logic          rd1_rvalid,
    output logic [31:0]   rd1_data,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    output logic          err_misalign
);
    localparam int ROW_W = $clog2(ROWS);

    logic              ok0, ok1, okw;
    logic              take0, take1, takew;
    logic [ROW_W-1:0]  row0, row1, roww;
    logic [1:0]        pair0, pair1, pairw;
    logic [1:0]        pair0_q, pair1_q;
    logic [HWIDTH-1:0] bank_q [NBANK];

    assign ok0 = (rd0_addr[1:0] == 2'b00);
    assign ok1 = (rd1_addr[1:0] == 2'b00);
    assign okw = (wr_addr[1:0] == 2'b00);

    assign row0  = rd0_addr[AW-1:4];
    assign row1  = rd1_addr[AW-1:4];
    assign roww  = wr_addr[AW-1:4];
    assign pair0 = rd0_addr[3:2];
    assign pair1 = rd1_addr[3:2];
    assign pairw = wr_addr[3:2];

    bdr_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd0_valid (rd0_valid),
        .rd1_valid (rd1_valid),
        .rd0_ok    (ok0),
        .rd1_ok    (ok1),
        .same_half (rd0_addr[2] == rd1_addr[2]),
        .rd0_ready (rd0_ready),
        .rd1_ready (rd1_ready)
    );

    assign take0 = rd0_valid && rd0_ready && ok0;
    assign take1 = rd1_valid && rd1_ready && ok1;
    assign takew = wr_valid && okw;

    for (genvar k = 0; k < NBANK; k++) begin : g_bank
        localparam logic [1:0] PAIR = 2'(k / 2);
        logic              hit0, hit1, we_k;
        logic [ROW_W-1:0]  raddr_k;
        logic [HWIDTH-1:0] wdata_k;

        assign hit0    = take0 && (pair0 == PAIR);
        assign hit1    = take1 && (pair1 == PAIR);
        assign raddr_k = hit0 ? row0 : row1;
        assign we_k    = takew && (pairw == PAIR);
        if (k % 2 == 1) begin : g_hi
            assign wdata_k = wr_data[WWIDTH-1:HWIDTH];
        end else begin : g_lo
            assign wdata_k = wr_data[HWIDTH-1:0];
        end

        bdr_bank #(.ROWS(ROWS), .ROW_W(ROW_W), .DW(HWIDTH)) u_bank (
            .clk   (clk),
            .we    (we_k),
            .waddr (roww),
            .wdata (wdata_k),
            .re    (hit0 || hit1),
            .raddr (raddr_k),
            .rdata (bank_q[k])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd0_rvalid   <= 1'b0;
            rd1_rvalid   <= 1'b0;
            err_misalign <= 1'b0;
            pair0_q      <= '0;
            pair1_q      <= '0;
        end else begin
            rd0_rvalid   <= take0;
            rd1_rvalid   <= take1;
            err_misalign <= (rd0_valid && rd0_ready && !ok0)
                         || (rd1_valid && rd1_ready && !ok1)
                         || (wr_valid && !okw);
            if (take0) pair0_q <= pair0;
            if (take1) pair1_q <= pair1;
        end
    end

    assign rd0_data = {bank_q[{pair0_q, 1'b1}], bank_q[{pair0_q, 1'b0}]};
    assign rd1_data = {bank_q[{pair1_q, 1'b1}], bank_q[{pair1_q, 1'b0}]};

    // R4: two reads served together never share a bank index modulo 4
    a_r4_no_clash_served: assert property (@(posedge clk) disable iff (!rst_n)
        (take0 && take1) |-> (rd0_addr[2] != rd1_addr[2]));

    // R6: port 0 data only follows an accepted aligned request
    a_r6_latency0: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_rvalid |-> $past(rd0_valid && rd0_ready && ok0));

    // R6: port 1 data only follows an accepted aligned request
    a_r6_latency1: assert property (@(posedge clk) disable iff (!rst_n)
        rd1_rvalid |-> $past(rd1_valid && rd1_ready && ok1));

    // R8: a misaligned read produces no data
    a_r8_drop_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_valid && rd0_ready && !ok0) |=> !rd0_rvalid);

    // R3: non-clashing aligned reads are both accepted at once
    a_r3_dual_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_valid && rd1_valid && ok0 && ok1 && rd0_addr[2] != rd1_addr[2]
         && $past(rd1_ready)) |-> (rd0_ready && rd1_ready));
endmodule

// File: tb/banked_dual_read_mem_bench.sv
module banked_dual_read_mem_bench;
    localparam int ROWS  = 16;
    localparam int AW    = $clog2(ROWS) + 4;
    localparam int WORDS = ROWS * 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rd0_valid, rd1_valid, wr_valid;
    logic [AW-1:0] rd0_addr, rd1_addr, wr_addr;
    logic [31:0]   wr_data;
    logic          rd0_ready, rd1_ready, rd0_rvalid, rd1_rvalid, err_misalign;
    logic [31:0]   rd0_data, rd1_data;

    banked_dual_read_mem #(.ROWS(ROWS)) u_banked_dual_read_mem (
        .clk(clk), .rst_n(rst_n),
        .rd0_valid(rd0_valid), .rd0_addr(rd0_addr), .rd0_ready(rd0_ready),
        .rd0_rvalid(rd0_rvalid), .rd0_data(rd0_data),
        .rd1_valid(rd1_valid), .rd1_addr(rd1_addr), .rd1_ready(rd1_ready),
        .rd1_rvalid(rd1_rvalid), .rd1_data(rd1_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .err_misalign(err_misalign)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] d;
        int          due;
    } exp_t;
    exp_t q0[$];
    exp_t q1[$];

    logic [31:0] model [WORDS];
    bit hold_b = 1'b0;

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // monitor: pop the scoreboard when results appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd0_rvalid) begin
                if (q0.size() == 0) chk(1'b0, "R8", "port0 unexpected data", rd0_data, 32'h0);
                else begin
                    exp_t e;
                    e = q0.pop_front();
                    chk(rd0_data === e.d, "R2", "port0 data", rd0_data, e.d);
                    chk(cyc == e.due, "R6", "port0 due cycle", cyc, e.due);
                end
            end
            if (rd1_rvalid) begin
                if (q1.size() == 0) chk(1'b0, "R8", "port1 unexpected data", rd1_data, 32'h0);
                else begin
                    exp_t e;
                    e = q1.pop_front();
                    chk(rd1_data === e.d, "R2", "port1 data", rd1_data, e.d);
                    chk(cyc == e.due, "R6", "port1 due cycle", cyc, e.due);
                end
            end
        end
    end

    // driver: port 0 may carry a second request after the first is taken
    task automatic issue(bit v0, logic [AW-1:0] a0, bit v0b, logic [AW-1:0] a0b,
                         bit v1, logic [AW-1:0] a1,
                         bit vw, logic [AW-1:0] aw, logic [31:0] dw);
        bit p0 = v0, p0b = v0b, p1 = v1, pw = vw;
        logic [AW-1:0] c0 = a0;
        @(negedge clk);
        while (p0 || p0b || p1 || pw) begin
            bit clash, e0, e1, misal, wdo;
            if (!p0 && p0b) begin p0 = 1'b1; p0b = 1'b0; c0 = a0b; end
            rd0_valid = p0; rd0_addr = c0;
            rd1_valid = p1; rd1_addr = a1;
            wr_valid = pw; wr_addr = aw; wr_data = dw;
            #1;
            clash = p0 && p1 && c0[1:0] == 2'b00 && a1[1:0] == 2'b00 && c0[2] == a1[2];
            e0 = hold_b ? !clash : 1'b1;
            e1 = hold_b ? 1'b1 : !clash;
            chk(rd0_ready == e0, hold_b ? "R5" : "R3", "port0 ready", 32'(rd0_ready), 32'(e0));
            chk(rd1_ready == e1, hold_b ? "R5" : "R4", "port1 ready", 32'(rd1_ready), 32'(e1));
            misal = 1'b0;
            wdo = 1'b0;
            if (p0 && e0) begin
                if (c0[1:0] == 2'b00) q0.push_back('{model[c0[AW-1:2]], cyc + 1});
                else misal = 1'b1;
                p0 = 1'b0;
            end
            if (p1 && e1) begin
                if (a1[1:0] == 2'b00) q1.push_back('{model[a1[AW-1:2]], cyc + 1});
                else misal = 1'b1;
                p1 = 1'b0;
            end
            if (pw) begin
                if (aw[1:0] != 2'b00) misal = 1'b1;
                else wdo = 1'b1;
                pw = 1'b0;
            end
            hold_b = !hold_b && clash;
            @(posedge clk);
            if (wdo) model[aw[AW-1:2]] = dw;
            @(negedge clk);
            chk(err_misalign == misal, "R8", "error flag", 32'(err_misalign), 32'(misal));
            rd0_valid = 1'b0; rd1_valid = 1'b0; wr_valid = 1'b0;
        end
    endtask

    function automatic logic [31:0] pat(int i);
        return {16'h1100 + 16'(i), ~16'(i)};
    endfunction

    initial begin
        #(150000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        rst_n = 1'b0;
        rd0_valid = 1'b0; rd1_valid = 1'b0; wr_valid = 1'b0;
        rd0_addr = '0; rd1_addr = '0; wr_addr = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(rd0_ready == 1'b1, "R1", "port0 ready", 32'(rd0_ready), 32'd1);
        chk(rd1_ready == 1'b1, "R1", "port1 ready", 32'(rd1_ready), 32'd1);
        chk(rd0_rvalid == 1'b0 && rd1_rvalid == 1'b0, "R1", "rvalid", 32'(rd0_rvalid), 32'd0);
        chk(err_misalign == 1'b0, "R1", "error flag", 32'(err_misalign), 32'd0);

        // R2: fill every word, read back on each port
        for (int i = 0; i < WORDS; i++) issue(0, '0, 0, '0, 0, '0, 1, AW'(i * 4), pat(i));
        for (int i = 0; i < WORDS; i++) issue(1, AW'(i * 4), 0, '0, 0, '0, 0, '0, '0);
        for (int i = 0; i < WORDS; i += 5) issue(0, '0, 0, '0, 1, AW'(i * 4), 0, '0, '0);

        // R3: bit 2 differs, both served in one cycle
        issue(1, AW'('h00), 0, '0, 1, AW'('h04), 0, '0, '0);
        issue(1, AW'('h1C), 0, '0, 1, AW'('h30), 0, '0, '0);

        // R4: same bank, and banks equal modulo 4 (0 and 4)
        issue(1, AW'('h00), 0, '0, 1, AW'('h10), 0, '0, '0);
        issue(1, AW'('h00), 0, '0, 1, AW'('h08), 0, '0, '0);

        // R5: a clashing port0 request during hold waits; a clear one is taken
        issue(1, AW'('h00), 1, AW'('h20), 1, AW'('h10), 0, '0, '0);
        issue(1, AW'('h00), 1, AW'('h24), 1, AW'('h10), 0, '0, '0);

        // R7: read and write the same word in one cycle
        issue(1, AW'('h08), 0, '0, 0, '0, 1, AW'('h08), 32'hCAFE_0008);
        issue(0, '0, 0, '0, 1, AW'('h0C), 1, AW'('h0C), 32'hCAFE_000C);
        issue(1, AW'('h08), 0, '0, 1, AW'('h0C), 0, '0, '0);

        // R8: misaligned read and write are flagged and dropped
        issue(1, AW'('h02), 0, '0, 1, AW'('h10), 0, '0, '0);
        issue(0, '0, 0, '0, 1, AW'('h15), 0, '0, '0);
        issue(0, '0, 0, '0, 0, '0, 1, AW'('h06), 32'hDEAD_BEEF);
        issue(1, AW'('h04), 0, '0, 1, AW'('h08), 0, '0, '0);

        // R9: a write during a clash is still stored
        issue(1, AW'('h00), 0, '0, 1, AW'('h10), 1, AW'('h30), 32'h0BAD_F00D);
        issue(1, AW'('h30), 0, '0, 0, '0, 0, '0, '0);

        repeat (3) @(negedge clk);
        chk(q0.size() == 0, "R6", "port0 results outstanding", 32'(q0.size()), 32'd0);
        chk(q1.size() == 0, "R6", "port1 results outstanding", 32'(q1.size()), 32'd0);
        report();
    end
endmodule